// File: doc/BRIEF.md
# Boot-time multi-region address remapper

This block sits on the request path between a processor's memory port and the downstream system bus. Right after power-up it applies a boot map: any access whose address falls inside one of several configured relocation windows is steered to that window's destination base, so that, for example, a ROM can answer at address zero. Accesses outside every window, and all accesses once the boot map has been retired, are forwarded untouched.

Each window has an inclusive lower bound, an inclusive upper bound and a destination base; the forwarded address is the destination plus the offset of the access into the window. A jumper-style input, sampled while reset is held, chooses whether the block comes up in the boot map or directly in the normal map. A one-cycle clear pulse from the control registers retires the boot map for good; only a new reset brings it back. Translation is purely combinational, so valid, ready, direction, write data and read data cross the block with no added cycle.

Top module: `boot_remapper`

## Requirements
- R1: In the boot map, an access whose address lies in window i is forwarded with address dst_i + (addr − lo_i), taken modulo 2^ADDR_W.
- R2: Window bounds are inclusive: addresses lo_i and hi_i are translated, while lo_i − 1 and hi_i + 1 are not translated by window i.
- R3: When an address lies in more than one window, the window with the lowest index decides the translation.
- R4: In the boot map, an address outside every window is forwarded unchanged.
- R5: In the normal map every address is forwarded unchanged.
- R6: The value of boot_en during reset sets the starting map: 1 selects the boot map, 0 the normal map.
- R7: A map_clear pulse in a cycle with no stalled request (a stalled request is up_valid=1 with dn_ready=0) makes the normal map active from the next cycle.
- R8: The normal map is sticky: further map_clear pulses change nothing, and only a reset with boot_en=1 restores the boot map.
- R9: A map_clear pulse that arrives while a request is stalled leaves that request's forwarded address unchanged until it is accepted; the normal map takes effect from the cycle after the acceptance.
- R10: dn_valid, dn_write and dn_wdata equal up_valid, up_write and up_wdata, and up_ready and up_rdata equal dn_ready and dn_rdata, in the same cycle.
- R11: A window whose lower bound exceeds its upper bound matches no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| boot_en | input | 1 | Jumper: 1 starts in the boot map, sampled during reset |
| map_clear | input | 1 | One-cycle pulse retiring the boot map |
| cfg_lo | input | NREG*ADDR_W | Inclusive lower bound per window, window i at bits [i*ADDR_W +: ADDR_W] |
| cfg_hi | input | NREG*ADDR_W | Inclusive upper bound per window |
| cfg_dst | input | NREG*ADDR_W | Destination base per window |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request accepted |
| up_write | input | 1 | 1 for write, 0 for read |
| up_addr | input | ADDR_W | Upstream address |
| up_wdata | input | DATA_W | Upstream write data |
| up_rdata | output | DATA_W | Read data returned upstream |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request accepted |
| dn_write | output | 1 | Downstream direction |
| dn_addr | output | ADDR_W | Downstream (possibly translated) address |
| dn_wdata | output | DATA_W | Downstream write data |
| dn_rdata | input | DATA_W | Read data from downstream |

## Verification
The bench sweeps every address of an 8-bit space in both maps against a window set with an overlap, a destination that wraps past the top of the space and an empty window, so an off-by-one bound, a wrong priority order or a missing modulo shows up as a mismatched forwarded address. It pulses the clear while a request is stalled: a design that switched maps at once would change the address of the request still waiting. It also pulses the clear a second time and resets with each jumper value, catching a map that toggles back or ignores the jumper.

// File: rtl/remap_pkg.sv
package remap_pkg;
  typedef enum logic {MAP_NORMAL = 1'b0, MAP_BOOT = 1'b1} map_mode_t;
endpackage

// File: rtl/region_window.sv
module region_window #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [ADDR_W-1:0] dst,
  output logic              hit,
  output logic [ADDR_W-1:0] xaddr
);
  // Inclusive containment test.
  function automatic logic inside_window(input logic [ADDR_W-1:0] a,
                                         input logic [ADDR_W-1:0] l,
                                         input logic [ADDR_W-1:0] h);
    return (a >= l) && (a <= h);
  endfunction

  // Destination plus offset, wrapping at the address width.
  function automatic logic [ADDR_W-1:0] relocate(input logic [ADDR_W-1:0] a,
                                                 input logic [ADDR_W-1:0] l,
                                                 input logic [ADDR_W-1:0] d);
    return d + (a - l);
  endfunction

  assign hit   = inside_window(addr, lo, hi);
  assign xaddr = relocate(addr, lo, dst);

  // R1: a hit lands no further from the base than the window's span
  a_r1_offset_in_span: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((xaddr - dst) <= (hi - lo)));
  // R11: an inverted window never hits
  a_r11_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
    (lo > hi) |-> !hit);
endmodule

// File: rtl/first_hit_select.sv
module first_hit_select #(
  parameter int ADDR_W = 12,
  parameter int NREG   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [NREG-1:0]        hits,
  input  logic [NREG*ADDR_W-1:0] xaddrs,
  output logic [NREG-1:0]        grant,
  output logic                   any_hit,
  output logic [ADDR_W-1:0]      sel_addr
);
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hits[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    sel_addr = addr;
    for (int i = 0; i < NREG; i++) begin
      if (grant[i]) sel_addr = xaddrs[i*ADDR_W +: ADDR_W];
    end
  end

  assign any_hit = |hits;

  // R3: at most one winner
  a_r3_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R3: a winner exists exactly when some window hits
  a_r3_grant_when_hit: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> (grant != '0));

  generate
    for (genvar g = 1; g < NREG; g++) begin : g_prio
      // R3: no lower-index window may also hit when window g wins
      a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        grant[g] |-> (hits[g-1:0] == '0));
    end
  endgenerate
endmodule

// File: rtl/map_mode_ctrl.sv
module map_mode_ctrl
  import remap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic boot_en,
  input  logic map_clear,
  input  logic stall,
  output logic boot_active
);
  map_mode_t mode_q, mode_d;
  logic      pend_q, pend_d;
  logic      clr_req, clr_apply;

  assign clr_req   = (map_clear || pend_q) && (mode_q == MAP_BOOT);
  assign clr_apply = clr_req && !stall;

  always_comb begin
    mode_d = mode_q;
    pend_d = clr_req && stall;
    if (clr_apply) mode_d = MAP_NORMAL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= boot_en ? MAP_BOOT : MAP_NORMAL;
      pend_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      pend_q <= pend_d;
    end
  end

  assign boot_active = (mode_q == MAP_BOOT);

  // R8: once normal, stays normal until reset
  a_r8_sticky_normal: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_active |=> !boot_active);
  // R9: the map never changes under a stalled request
  a_r9_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(boot_active));
  // R7: a clear outside a stall takes effect next cycle
  a_r7_clear_applies: assert property (@(posedge clk) disable iff (!rst_n)
    (map_clear && !stall) |=> !boot_active);
endmodule

// File: rtl/boot_remapper.sv
module boot_remapper #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int NREG   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   boot_en,
  input  logic                   map_clear,
  input  logic [NREG*ADDR_W-1:0] cfg_lo,
  input  logic [NREG*ADDR_W-1:0] cfg_hi,
  input  logic [NREG*ADDR_W-1:0] cfg_dst,
  input  logic                   up_valid,
  output logic                   up_ready,
  input  logic                   up_write,
  input  logic [ADDR_W-1:0]      up_addr,
  input  logic [DATA_W-1:0]      up_wdata,
  output logic [DATA_W-1:0]      up_rdata,
  output logic                   dn_valid,
  input  logic                   dn_ready,
  output logic                   dn_write,
  output logic [ADDR_W-1:0]      dn_addr,
  output logic [DATA_W-1:0]      dn_wdata,
  input  logic [DATA_W-1:0]      dn_rdata
);
  logic [NREG-1:0]        win_hit;
  logic [NREG*ADDR_W-1:0] win_xaddr;
  logic [NREG-1:0]        win_grant;
  logic                   any_hit;
  logic [ADDR_W-1:0]      sel_addr;
  logic                   boot_active;
  logic                   req_stall;

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_win
      region_window #(.ADDR_W(ADDR_W)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (up_addr),
        .lo    (cfg_lo[i*ADDR_W +: ADDR_W]),
        .hi    (cfg_hi[i*ADDR_W +: ADDR_W]),
        .dst   (cfg_dst[i*ADDR_W +: ADDR_W]),
        .hit   (win_hit[i]),
        .xaddr (win_xaddr[i*ADDR_W +: ADDR_W])
      );
    end
  endgenerate

  first_hit_select #(.ADDR_W(ADDR_W), .NREG(NREG)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (up_addr),
    .hits     (win_hit),
    .xaddrs   (win_xaddr),
    .grant    (win_grant),
    .any_hit  (any_hit),
    .sel_addr (sel_addr)
  );

  assign req_stall = up_valid && !dn_ready;

  map_mode_ctrl u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .boot_en     (boot_en),
    .map_clear   (map_clear),
    .stall       (req_stall),
    .boot_active (boot_active)
  );

  assign dn_addr  = boot_active ? sel_addr : up_addr;
  assign dn_valid = up_valid;
  assign dn_write = up_write;
  assign dn_wdata = up_wdata;
  assign up_ready = dn_ready;
  assign up_rdata = dn_rdata;

  // R5: normal map is transparent
  a_r5_normal_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_active |-> (dn_addr == up_addr));
  // R4: a miss in the boot map is transparent
  a_r4_miss_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_active && !any_hit) |-> (dn_addr == up_addr));
  // R9: a stalled request keeps its forwarded address
  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_stall && $stable(up_addr)) |=> (!$stable(up_addr) || $stable(dn_addr)));
endmodule

// File: tb/boot_remapper_tb.sv
module boot_remapper_tb;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NR = 4;

  logic clk = 1'b0;
  logic rst_n, boot_en, map_clear;
  logic [NR*AW-1:0] cfg_lo, cfg_hi, cfg_dst;
  logic up_valid, up_ready, up_write, dn_valid, dn_ready, dn_write;
  logic [AW-1:0] up_addr, dn_addr;
  logic [DW-1:0] up_wdata, up_rdata, dn_wdata, dn_rdata;

  int n_checks = 0;
  int n_errors = 0;

  always #10 clk = ~clk;

  boot_remapper #(.ADDR_W(AW), .DATA_W(DW), .NREG(NR)) u_dut (
    .clk(clk), .rst_n(rst_n), .boot_en(boot_en), .map_clear(map_clear),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_dst(cfg_dst),
    .up_valid(up_valid), .up_ready(up_ready), .up_write(up_write),
    .up_addr(up_addr), .up_wdata(up_wdata), .up_rdata(up_rdata),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
  );

  // Windows: 0 [10,1F]->A0, 1 [18,3F]->C0 (overlaps 0), 2 [F0,FF]->F8 (wraps), 3 [80,7F] empty
  int lo_t[NR]  = '{8'h10, 8'h18, 8'hF0, 8'h80};
  int hi_t[NR]  = '{8'h1F, 8'h3F, 8'hFF, 8'h7F};
  int dst_t[NR] = '{8'hA0, 8'hC0, 8'hF8, 8'h00};

  function automatic int expect_boot(input int a);
    for (int r = 0; r < NR; r++)
      if (a >= lo_t[r] && a <= hi_t[r]) return (dst_t[r] + a - lo_t[r]) % 256;
    return a;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic jumper);
    @(negedge clk);
    rst_n = 1'b0; boot_en = jumper;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic sweep(input logic boot);
    for (int a = 0; a < 256; a++) begin
      up_addr = a[AW-1:0];
      #1;
      if (!boot) chk("R5", int'(dn_addr), a);
      else if (a == 8'h0F || a == 8'h40) chk("R2", int'(dn_addr), a);
      else if (a >= 8'h18 && a <= 8'h1F) chk("R3", int'(dn_addr), expect_boot(a));
      else if (a == 8'h7F || a == 8'h80) chk("R11", int'(dn_addr), a);
      else if (a == 8'h10 || a == 8'h3F || a == 8'hFF) chk("R2", int'(dn_addr), expect_boot(a));
      else if (expect_boot(a) == a) chk("R4", int'(dn_addr), a);
      else chk("R1", int'(dn_addr), expect_boot(a));
    end
  endtask

  initial begin
    for (int r = 0; r < NR; r++) begin
      cfg_lo[r*AW +: AW]  = lo_t[r][AW-1:0];
      cfg_hi[r*AW +: AW]  = hi_t[r][AW-1:0];
      cfg_dst[r*AW +: AW] = dst_t[r][AW-1:0];
    end
    rst_n = 1'b0; boot_en = 1'b1; map_clear = 1'b0;
    up_valid = 1'b0; up_write = 1'b0; up_addr = '0; up_wdata = '0;
    dn_ready = 1'b1; dn_rdata = '0;

    // R6: jumper high starts in the boot map
    do_reset(1'b1);
    @(negedge clk); up_addr = 8'h10; #1;
    chk("R6", int'(dn_addr), 8'hA0);
    sweep(1'b1);

    // R10: side signals pass through in the same cycle
    @(negedge clk);
    up_valid = 1'b1; up_write = 1'b1; up_wdata = 16'hBEEF; dn_rdata = 16'h1234; dn_ready = 1'b0; #1;
    chk("R10", int'(dn_valid), 1); chk("R10", int'(dn_write), 1);
    chk("R10", int'(dn_wdata), 16'hBEEF); chk("R10", int'(up_rdata), 16'h1234);
    chk("R10", int'(up_ready), 0);
    up_write = 1'b0; dn_ready = 1'b1; #1;
    chk("R10", int'(dn_write), 0); chk("R10", int'(up_ready), 1);

    // R9: clear during a stalled request is deferred
    @(negedge clk);
    up_valid = 1'b1; dn_ready = 1'b0; up_addr = 8'h12; map_clear = 1'b1;
    @(negedge clk); map_clear = 1'b0; #1;
    chk("R9", int'(dn_addr), 8'hA2);
    @(negedge clk); #1;
    chk("R9", int'(dn_addr), 8'hA2);
    dn_ready = 1'b1; #1;
    chk("R9", int'(dn_addr), 8'hA2);
    @(negedge clk); up_valid = 1'b0; #1;
    chk("R9", int'(dn_addr), 8'h12);
    sweep(1'b0);

    // R8: another clear leaves the normal map in place
    @(negedge clk); map_clear = 1'b1;
    @(negedge clk); map_clear = 1'b0;
    @(negedge clk); up_addr = 8'h20; #1;
    chk("R8", int'(dn_addr), 8'h20);

    // R8: reset with jumper high restores the boot map
    do_reset(1'b1);
    @(negedge clk); up_addr = 8'h20; #1;
    chk("R8", int'(dn_addr), 8'hC8);

    // R7: clear with no stall applies next cycle
    up_valid = 1'b0; map_clear = 1'b1; #1;
    chk("R7", int'(dn_addr), 8'hC8);
    @(negedge clk); map_clear = 1'b0; #1;
    chk("R7", int'(dn_addr), 8'h20);

    // R6: jumper low starts in the normal map
    do_reset(1'b0);
    @(negedge clk); up_addr = 8'h10; #1;
    chk("R6", int'(dn_addr), 8'h10);
    up_addr = 8'hF5; #1;
    chk("R6", int'(dn_addr), 8'hF5);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule